// File: doc/BRIEF.md
# Supply Shutdown Sequencer

This block drives an active-low shutdown output that keeps an external power supply alive. Two stored enable bits control it: a clock-generator enable and a supply-hold enable, written one at a time by a host. While either bit is set, the output stays high and the supply stays on. When a write or a sleep-entry command leaves both bits clear, the output does not drop at once. It stays high for a fixed number of ticks of a slow timebase, so the host has time to finish its own shutdown. The default is 96 ticks of a 32.768 kHz strobe, about 2.93 ms.

A sleep-entry command clears both bits in one step and counts as a power-down command. A wake-up event raises the output from any state. The output then stays high until the next power-down command starts a new hold period. If either bit is set again during the hold period, the countdown is abandoned. The next power-down command then starts the full count again.

Top module: `shdn_seq`

## Requirements
- R1: After reset, both enable bits read 0 and `psu_shdn_no` is low.
- R2: A write of 1 to the clock-generator bit (`pll_we_i`=1, `pll_d_i`=1, `sleep_i`=0) makes `pll_en_o` and `psu_shdn_no` high at the next clock edge.
- R3: A write of 1 to the supply-hold bit (`sde_we_i`=1, `sde_d_i`=1, `sleep_i`=0) makes `sde_en_o` and `psu_shdn_no` high at the next clock edge.
- R4: While either enable bit is 1, `psu_shdn_no` is high. Clearing one bit while the other is still set starts no hold period.
- R5: A power-down command is a cycle with a write or a sleep-entry command after which both bits are 0. It starts a hold period. `psu_shdn_no` stays high until the HOLD_TICKS-th `tick_i` pulse sampled after the command cycle, and goes low at that same clock edge. A tick in the command cycle itself does not count.
- R6: `sleep_i` clears both bits at the next edge. It takes priority over any write in the same cycle and counts as a power-down command.
- R7: `wake_i` makes `psu_shdn_no` high at the next edge from any state, including during a hold period. The output then stays high, with the bits unchanged, until the next power-down command.
- R8: Setting either bit during a hold period cancels the countdown and keeps the output high. A later power-down command restarts the full HOLD_TICKS count.
- R9: `tick_i` has no effect on the output while the output is high and no hold period is running.
- R10: A further power-down command during a running hold period does not restart or extend the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Single-cycle strobe of the slow hold timebase |
| pll_we_i | input | 1 | Write strobe for the clock-generator enable bit |
| pll_d_i | input | 1 | Value written to the clock-generator enable bit |
| sde_we_i | input | 1 | Write strobe for the supply-hold enable bit |
| sde_d_i | input | 1 | Value written to the supply-hold enable bit |
| sleep_i | input | 1 | Sleep-entry command; clears both bits |
| wake_i | input | 1 | Wake-up event |
| pll_en_o | output | 1 | Current clock-generator enable bit |
| sde_en_o | output | 1 | Current supply-hold enable bit |
| psu_shdn_no | output | 1 | Shutdown output, active low (high keeps the supply on) |

## Verification
Several properties are checked on every cycle:
- a set write or a wake event always raises the output one edge later;
- a set bit always implies a high output;
- sleep always leaves both bits clear;
- the output never falls except on a tick edge;
- the output never rises without a set write or a wake event.

The exact length of the hold period is shown only by the bench's scenarios: the output must still be high after HOLD_TICKS-1 ticks and low after the last one. The same applies to the full restart after a cancelled countdown, to the ignored second power-down command, and to the output staying high after a wake until a command arrives.

// File: rtl/shdn_pkg.sv
package shdn_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ON   = 2'd1,
    ST_HOLD = 2'd2
  } shdn_state_e;
endpackage

// File: rtl/shdn_bits.sv
module shdn_bits (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pll_we_i,
  input  logic pll_d_i,
  input  logic sde_we_i,
  input  logic sde_d_i,
  input  logic sleep_i,
  output logic pll_q_o,
  output logic sde_q_o,
  output logic demand_nx_o,
  output logic pwrdn_cmd_o
);
  logic pll_nx, sde_nx;

  always_comb begin
    pll_nx = pll_q_o;
    sde_nx = sde_q_o;
    if (sleep_i) begin
      pll_nx = 1'b0;
      sde_nx = 1'b0;
    end else begin
      if (pll_we_i) pll_nx = pll_d_i;
      if (sde_we_i) sde_nx = sde_d_i;
    end
  end

  assign demand_nx_o = pll_nx | sde_nx;
  // any access that leaves both bits clear is a power-down command
  assign pwrdn_cmd_o = (sleep_i | pll_we_i | sde_we_i) & ~demand_nx_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pll_q_o <= 1'b0;
      sde_q_o <= 1'b0;
    end else begin
      pll_q_o <= pll_nx;
      sde_q_o <= sde_nx;
    end
  end
endmodule

// File: rtl/shdn_hold_timer.sv
module shdn_hold_timer #(
  parameter int unsigned HOLD_TICKS = 96,
  localparam int unsigned CNT_W = $clog2(HOLD_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HOLD_TICKS);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i & tick_i & (cnt_q == LAST_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= LOAD_VAL;
    end else if (run_i && tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - LAST_VAL;
    end
  end
endmodule

// File: rtl/shdn_seq.sv
module shdn_seq #(
  parameter int unsigned HOLD_TICKS = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pll_we_i,
  input  logic pll_d_i,
  input  logic sde_we_i,
  input  logic sde_d_i,
  input  logic sleep_i,
  input  logic wake_i,
  output logic pll_en_o,
  output logic sde_en_o,
  output logic psu_shdn_no
);
  import shdn_pkg::*;

  shdn_state_e st_q, st_nx;
  logic demand_nx, pwrdn_cmd, expire, load_tmr;

  shdn_bits i_bits (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pll_we_i   (pll_we_i),
    .pll_d_i    (pll_d_i),
    .sde_we_i   (sde_we_i),
    .sde_d_i    (sde_d_i),
    .sleep_i    (sleep_i),
    .pll_q_o    (pll_en_o),
    .sde_q_o    (sde_en_o),
    .demand_nx_o(demand_nx),
    .pwrdn_cmd_o(pwrdn_cmd)
  );

  shdn_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) i_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_tmr),
    .run_i   (st_q == ST_HOLD),
    .tick_i  (tick_i),
    .expire_o(expire)
  );

  always_comb begin
    st_nx    = st_q;
    load_tmr = 1'b0;
    unique case (st_q)
      ST_OFF:  if (demand_nx || wake_i) st_nx = ST_ON;
      ST_ON: begin
        if (pwrdn_cmd && !wake_i) begin
          st_nx    = ST_HOLD;
          load_tmr = 1'b1;
        end
      end
      ST_HOLD: begin
        // a re-set bit or wake cancels; a repeated command is ignored
        if (demand_nx || wake_i) st_nx = ST_ON;
        else if (expire)         st_nx = ST_OFF;
      end
      default: st_nx = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF;
    else         st_q <= st_nx;
  end

  assign psu_shdn_no = (st_q != ST_OFF);
endmodule

// File: rtl/shdn_seq_chk.sv
module shdn_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic pll_we_i,
  input logic pll_d_i,
  input logic sde_we_i,
  input logic sde_d_i,
  input logic sleep_i,
  input logic wake_i,
  input logic pll_en_o,
  input logic sde_en_o,
  input logic psu_shdn_no
);
  logic set_wr;
  assign set_wr = !sleep_i && ((pll_we_i && pll_d_i) || (sde_we_i && sde_d_i));

  AST_SET_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr |=> psu_shdn_no); // R2
  AST_SDE_SET_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && sde_we_i && sde_d_i) |=> sde_en_o); // R3
  AST_BIT_KEEPS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_en_o || sde_en_o) |-> psu_shdn_no); // R4
  AST_FALL_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(psu_shdn_no) |-> $past(tick_i)); // R5
  AST_SLEEP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (!pll_en_o && !sde_en_o)); // R6
  AST_WAKE_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> psu_shdn_no); // R7
  AST_RISE_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(psu_shdn_no) |-> $past(set_wr || wake_i)); // R2
endmodule

bind shdn_seq shdn_seq_chk i_shdn_seq_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .pll_we_i   (pll_we_i),
  .pll_d_i    (pll_d_i),
  .sde_we_i   (sde_we_i),
  .sde_d_i    (sde_d_i),
  .sleep_i    (sleep_i),
  .wake_i     (wake_i),
  .pll_en_o   (pll_en_o),
  .sde_en_o   (sde_en_o),
  .psu_shdn_no(psu_shdn_no)
);

// File: tb/test_shdn_seq.sv
`timescale 1ns/1ps
module test_shdn_seq;
  localparam int unsigned N = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, pll_we = 0, pll_d = 0, sde_we = 0, sde_d = 0, sleep = 0, wake = 0;
  logic pll_en, sde_en, shdn_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  logic m_pll = 0, m_sde = 0;
  int   m_st = 0;   // 0 off, 1 on, 2 hold
  int   m_cnt = 0;

  always #2.5 clk = ~clk;

  shdn_seq #(.HOLD_TICKS(N)) i_shdn_seq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .pll_we_i(pll_we), .pll_d_i(pll_d), .sde_we_i(sde_we), .sde_d_i(sde_d),
    .sleep_i(sleep), .wake_i(wake),
    .pll_en_o(pll_en), .sde_en_o(sde_en), .psu_shdn_no(shdn_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_out();
    return m_st != 0;
  endfunction

  task automatic model_step();
    logic np, ns, dem, cmd;
    np = m_pll; ns = m_sde;
    if (sleep) begin np = 0; ns = 0; end
    else begin
      if (pll_we) np = pll_d;
      if (sde_we) ns = sde_d;
    end
    dem = np | ns;
    cmd = (sleep | pll_we | sde_we) & ~dem;
    case (m_st)
      0: if (dem || wake) m_st = 1;
      1: if (cmd && !wake) begin m_st = 2; m_cnt = N; end
      default: begin
        if (dem || wake) m_st = 1;
        else if (tick) begin
          if (m_cnt == 1) m_st = 0;
          else m_cnt--;
        end
      end
    endcase
    m_pll = np; m_sde = ns;
  endtask

  // one clock with current inputs; model compared every cycle
  task automatic cyc();
    @(posedge clk);
    model_step();
    #1;
    chk(shdn_n === exp_out(), "R2/R3/R5/R6/R7/R8/R10 model out", shdn_n, exp_out());
    chk(pll_en === m_pll && sde_en === m_sde, "R2/R3/R6 model bits",
        {pll_en, sde_en}, {m_pll, m_sde});
    tick = 0; pll_we = 0; pll_d = 0; sde_we = 0; sde_d = 0; sleep = 0; wake = 0;
  endtask

  task automatic wr_pll(input logic v);
    pll_we = 1; pll_d = v; cyc();
  endtask
  task automatic wr_sde(input logic v);
    sde_we = 1; sde_d = v; cyc();
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; cyc(); end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0b07));
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk(shdn_n === 1'b0, "R1 reset output", shdn_n, 0);
    chk(pll_en === 1'b0 && sde_en === 1'b0, "R1 reset bits", {pll_en, sde_en}, 0);

    // R2 then R5 exact hold length
    wr_pll(1);
    chk(shdn_n === 1'b1 && pll_en === 1'b1, "R2 pll set", shdn_n, 1);
    wr_pll(0);
    chk(shdn_n === 1'b1, "R5 command start high", shdn_n, 1);
    ticks(N - 1);
    chk(shdn_n === 1'b1, "R5 high before last tick", shdn_n, 1);
    ticks(1);
    chk(shdn_n === 1'b0, "R5 low after last tick", shdn_n, 0);

    // R3, R4, R9
    wr_sde(1);
    chk(shdn_n === 1'b1 && sde_en === 1'b1, "R3 sde set", shdn_n, 1);
    wr_pll(1);
    wr_sde(0);
    ticks(N + 10);
    chk(shdn_n === 1'b1, "R4 R9 pll keeps output", shdn_n, 1);

    // R8 cancel and full restart
    wr_pll(0);
    ticks(10);
    wr_sde(1);
    chk(shdn_n === 1'b1, "R8 cancel high", shdn_n, 1);
    ticks(N);
    chk(shdn_n === 1'b1, "R8 no countdown after cancel", shdn_n, 1);
    wr_sde(0);
    ticks(N - 1);
    chk(shdn_n === 1'b1, "R8 full restart", shdn_n, 1);
    ticks(1);
    chk(shdn_n === 1'b0, "R8 restart expires", shdn_n, 0);

    // R6 sleep beats same-cycle write
    wr_sde(1);
    sleep = 1; pll_we = 1; pll_d = 1; cyc();
    chk(pll_en === 1'b0 && sde_en === 1'b0, "R6 sleep clears", {pll_en, sde_en}, 0);
    chk(shdn_n === 1'b1, "R6 sleep hold high", shdn_n, 1);
    ticks(N);
    chk(shdn_n === 1'b0, "R6 sleep hold expires", shdn_n, 0);

    // R7 wake from off, stays high until command
    wake = 1; cyc();
    chk(shdn_n === 1'b1, "R7 wake raises", shdn_n, 1);
    chk(pll_en === 1'b0 && sde_en === 1'b0, "R7 bits unchanged", {pll_en, sde_en}, 0);
    ticks(2 * N);
    chk(shdn_n === 1'b1, "R7 stays high", shdn_n, 1);
    wr_sde(0);
    ticks(N - 5);
    wake = 1; cyc();
    chk(shdn_n === 1'b1, "R7 wake during hold", shdn_n, 1);
    ticks(N);
    chk(shdn_n === 1'b1, "R7 wake cancels hold", shdn_n, 1);

    // R10 repeat command ignored
    wr_pll(0);
    ticks(50);
    wr_sde(0);
    ticks(N - 51);
    chk(shdn_n === 1'b1, "R10 before last", shdn_n, 1);
    ticks(1);
    chk(shdn_n === 1'b0, "R10 no restart", shdn_n, 0);

    // constrained random
    for (int i = 0; i < 20000; i++) begin
      tick   = ($urandom % 3) == 0;
      pll_we = ($urandom % 97) == 0;
      pll_d  = $urandom % 2;
      sde_we = ($urandom % 89) == 0;
      sde_d  = $urandom % 2;
      sleep  = ($urandom % 401) == 0;
      wake   = ($urandom % 503) == 0;
      cyc();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule